// File: doc/BRIEF.md
# Two-Cycle Multiplexed Memory Command Encoder

This block sits on the controller side of a low-power memory channel. It takes one high-level request at a time: activate a row, read, write, or precharge. Each request carries a bank, a row and a column. The block turns the request into a series of command frames on a narrow 6-bit command/address bus, which is sampled once per clock. Each frame takes two clock cycles. An active-high chip select is high on the first cycle and low on the second, so the receiving device can find the start of each frame. Row addresses are too wide for one frame, so they go out in two activation frames. Every read or write frame is followed by a column-completion frame that carries the low column bits.

The block keeps an open-row table with one entry for each of the eight banks. A read or write to an idle bank is preceded by the two activation frames. A read or write to a bank that has a different row open starts with a precharge and then reopens the bank. A read or write to the row that is already open goes straight to the access frames. Requests enter through a valid/ready handshake. Ready stays low while a sequence is being sent. When no frame is being sent, chip select is low and the bus carries all zeros.

Top module: `lp_cmd_encoder`

## Requirements
- R1: After reset, and on every cycle on which no frame is being sent, `cs` is 0, `ca` is all zeros and `req_ready` is 1.
- R2: Every command frame lasts exactly two cycles, with `cs` 1 on the first cycle and 0 on the second. On the first cycle `ca[2:0]` holds the opcode and `ca[5:3]` holds the bank. The opcodes are ACT1=1, ACT2=2, RD=3, WR=4, CAS2=5 and PRE=6. CAS2 carries bank field 0. The request opcodes on `req_op` are 0=activate, 1=read, 2=write and 3=precharge.
- R3: An activate request to an idle bank produces ACT1 followed by ACT2. The second cycle of ACT1 carries `req_row[11:6]` and the second cycle of ACT2 carries `req_row[5:0]`. The first frame starts in the cycle after the request is accepted.
- R4: A read to an idle bank produces ACT1, ACT2, RD and CAS2, which take eight cycles in total.
- R5: The second cycle of RD or WR carries `{burst_bit, 1'b0, req_col[9:6]}`. The next frame is always CAS2, and its second cycle carries `req_col[5:0]`.
- R6: In the default per-access burst mode, the burst bit equals `req_bl32` (1 selects 32 beats, 0 selects 16). In the two fixed modes the burst bit is the constant 0 or 1.
- R7: A read or write to a bank whose open row equals `req_row` sends only RD/WR and CAS2.
- R8: A read or write to a bank that has a different row open sends PRE first, with its second cycle all zeros, then ACT1, ACT2, RD/WR and CAS2. An activate request to an open bank also starts with PRE.
- R9: A precharge request to an open bank sends a single PRE frame and marks the bank idle, so the next read to that bank activates it again. A precharge request to an idle bank sends no frame, and the bus stays idle.
- R10: `req_ready` is 0 from the cycle after acceptance until the last cycle of the sequence. It returns to 1 in the cycle after the final frame cycle.
- R11: Each of the eight banks has its own open-row state. Opening or closing one bank does not change how requests to another bank are encoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | Request kind: 0 activate, 1 read, 2 write, 3 precharge |
| req_bank | input | 3 | Target bank |
| req_row | input | 12 | Row address |
| req_col | input | 10 | Column address |
| req_bl32 | input | 1 | Per-access burst select (1 = 32 beats) |
| cs | output | 1 | Chip select, high on the first cycle of each frame |
| ca | output | 6 | Command/address bus |

## Verification
A wrong bit in the open-row table does not show up at the ports until the next request to that bank. The fault then appears at once as a missing or extra PRE/ACT pair in the first frame after acceptance, so the tests revisit banks after they have been opened, closed, and reopened with a different row. A fault in the frame sequencer misaligns `cs` within a cycle, or puts the wrong payload on the second beat. The reference model compares both beats of every frame, and `req_ready`, on every cycle.

// File: rtl/lpce_pkg.sv
package lpce_pkg;
    localparam int CA_W         = 6;
    localparam int OP_W         = 3;
    localparam int BANK_FIELD_W = CA_W - OP_W;
    localparam int ROW_W        = 2 * CA_W;
    localparam int COL_HI_W     = CA_W - 2;
    localparam int COL_W        = CA_W + COL_HI_W;
    localparam int MAX_CMDS     = 5;
    localparam int CNT_W        = $clog2(MAX_CMDS + 1);

    typedef enum logic [1:0] {
        REQ_ACT = 2'd0,
        REQ_RD  = 2'd1,
        REQ_WR  = 2'd2,
        REQ_PRE = 2'd3
    } req_op_e;

    typedef enum logic [OP_W-1:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT1 = 3'd1,
        CMD_ACT2 = 3'd2,
        CMD_RD   = 3'd3,
        CMD_WR   = 3'd4,
        CMD_CAS2 = 3'd5,
        CMD_PRE  = 3'd6
    } cmd_op_e;

    typedef struct packed {
        cmd_op_e                 op;
        logic [BANK_FIELD_W-1:0] bank;
        logic [CA_W-1:0]         payload;
    } cmd_t;

    localparam cmd_t CMD_IDLE = '{op: CMD_NOP, bank: '0, payload: '0};

    function automatic logic [CA_W-1:0] first_beat(input cmd_t c);
        return {c.bank, c.op};
    endfunction

    function automatic cmd_t make_cmd(input cmd_op_e op,
                                      input logic [BANK_FIELD_W-1:0] bank,
                                      input logic [CA_W-1:0] payload);
        cmd_t c;
        c.op      = op;
        c.bank    = bank;
        c.payload = payload;
        return c;
    endfunction
endpackage

// File: rtl/lpce_bank_table.sv
module lpce_bank_table
    import lpce_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] look_bank,
    output logic              look_open,
    output logic [ROW_W-1:0]  look_row,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic              wr_open,
    input  logic [ROW_W-1:0]  wr_row
);
    logic [NUM_BANKS-1:0] open_q;
    logic [ROW_W-1:0]     row_q [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                open_q[b] <= 1'b0;
                row_q[b]  <= '0;
            end else if (wr_en && wr_bank == BANK_W'(b)) begin
                open_q[b] <= wr_open;
                if (wr_open) row_q[b] <= wr_row;
            end
        end
    end

    always_comb begin
        look_open = open_q[look_bank];
        look_row  = row_q[look_bank];
    end
endmodule

// File: rtl/lpce_planner.sv
module lpce_planner
    import lpce_pkg::*;
#(
    parameter int BANK_W     = 3,
    parameter int BURST_MODE = 2
) (
    input  logic [1:0]        req_op,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_bl32,
    input  logic              bank_open,
    input  logic [ROW_W-1:0]  bank_row,
    output cmd_t              plan [MAX_CMDS],
    output logic [CNT_W-1:0]  plan_cnt
);
    logic bl_bit;

    if (BURST_MODE == 0) begin : g_bl16
        assign bl_bit = 1'b0;
    end else if (BURST_MODE == 1) begin : g_bl32
        assign bl_bit = 1'b1;
    end else begin : g_bl_dyn
        assign bl_bit = req_bl32;
    end

    req_op_e                 op;
    logic                    is_access;
    logic                    row_hit;
    logic                    need_close;
    logic                    need_open;
    logic [BANK_FIELD_W-1:0] bank_f;
    logic [CNT_W-1:0]        n;

    always_comb begin
        op         = req_op_e'(req_op);
        bank_f     = BANK_FIELD_W'(req_bank);
        is_access  = (op == REQ_RD) || (op == REQ_WR);
        row_hit    = bank_open && (bank_row == req_row);
        need_close = bank_open && ((op == REQ_ACT) || (op == REQ_PRE) ||
                                   (is_access && !row_hit));
        need_open  = (op == REQ_ACT) || (is_access && !row_hit);

        for (int k = 0; k < MAX_CMDS; k++) plan[k] = CMD_IDLE;
        n = '0;
        if (need_close) begin
            plan[n] = make_cmd(CMD_PRE, bank_f, '0);
            n = n + CNT_W'(1);
        end
        if (need_open) begin
            plan[n] = make_cmd(CMD_ACT1, bank_f, req_row[ROW_W-1:CA_W]);
            n = n + CNT_W'(1);
            plan[n] = make_cmd(CMD_ACT2, bank_f, req_row[CA_W-1:0]);
            n = n + CNT_W'(1);
        end
        if (is_access) begin
            plan[n] = make_cmd((op == REQ_RD) ? CMD_RD : CMD_WR, bank_f,
                               {bl_bit, 1'b0, req_col[COL_W-1:CA_W]});
            n = n + CNT_W'(1);
            plan[n] = make_cmd(CMD_CAS2, '0, req_col[CA_W-1:0]);
            n = n + CNT_W'(1);
        end
        plan_cnt = n;
    end
endmodule

// File: rtl/lpce_serializer.sv
module lpce_serializer
    import lpce_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  cmd_t             plan [MAX_CMDS],
    input  logic [CNT_W-1:0] plan_cnt,
    output logic             busy,
    output logic             cs,
    output logic [CA_W-1:0]  ca
);
    cmd_t             list_q [MAX_CMDS];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] idx_q;
    logic             phase_q;
    logic             busy_q;
    cmd_t             cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            idx_q   <= '0;
            cnt_q   <= '0;
            for (int k = 0; k < MAX_CMDS; k++) list_q[k] <= CMD_IDLE;
        end else if (!busy_q) begin
            if (start && plan_cnt != '0) begin
                busy_q  <= 1'b1;
                phase_q <= 1'b0;
                idx_q   <= '0;
                cnt_q   <= plan_cnt;
                for (int k = 0; k < MAX_CMDS; k++) list_q[k] <= plan[k];
            end
        end else if (!phase_q) begin
            phase_q <= 1'b1;
        end else begin
            phase_q <= 1'b0;
            if (idx_q == cnt_q - CNT_W'(1)) busy_q <= 1'b0;
            else                            idx_q  <= idx_q + CNT_W'(1);
        end
    end

    always_comb begin
        cur  = list_q[idx_q];
        busy = busy_q;
        cs   = busy_q && !phase_q;
        if (!busy_q)      ca = '0;
        else if (phase_q) ca = cur.payload;
        else              ca = first_beat(cur);
    end

    // R2: chip select never stays high for two cycles in a row
    a_r2_cs_one_cycle: assert property (@(posedge clk) disable iff (rst)
        cs |=> !cs);

    // R3: the first activation frame is always followed by the second
    a_r3_act_pair: assert property (@(posedge clk) disable iff (rst)
        (cs && ca[OP_W-1:0] == CMD_ACT1) |=> ##1 (cs && ca[OP_W-1:0] == CMD_ACT2));

    // R5: every read or write frame is followed by a column-completion frame
    a_r5_cas_follows: assert property (@(posedge clk) disable iff (rst)
        (cs && (ca[OP_W-1:0] == CMD_RD || ca[OP_W-1:0] == CMD_WR))
        |=> ##1 (cs && ca[OP_W-1:0] == CMD_CAS2));
endmodule

// File: rtl/lp_cmd_encoder.sv
module lp_cmd_encoder
    import lpce_pkg::*;
#(
    parameter int NUM_BANKS  = 8,
    parameter int BURST_MODE = 2,
    localparam int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_bl32,
    output logic              cs,
    output logic [CA_W-1:0]   ca
);
    logic             accept;
    logic             busy;
    logic             look_open;
    logic [ROW_W-1:0] look_row;
    cmd_t             plan [MAX_CMDS];
    logic [CNT_W-1:0] plan_cnt;

    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;

    lpce_bank_table #(.NUM_BANKS(NUM_BANKS)) table_i (
        .clk       (clk),
        .rst       (rst),
        .look_bank (req_bank),
        .look_open (look_open),
        .look_row  (look_row),
        .wr_en     (accept),
        .wr_bank   (req_bank),
        .wr_open   (req_op != REQ_PRE),
        .wr_row    (req_row)
    );

    lpce_planner #(.BANK_W(BANK_W), .BURST_MODE(BURST_MODE)) planner_i (
        .req_op    (req_op),
        .req_bank  (req_bank),
        .req_row   (req_row),
        .req_col   (req_col),
        .req_bl32  (req_bl32),
        .bank_open (look_open),
        .bank_row  (look_row),
        .plan      (plan),
        .plan_cnt  (plan_cnt)
    );

    lpce_serializer ser_i (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .plan     (plan),
        .plan_cnt (plan_cnt),
        .busy     (busy),
        .cs       (cs),
        .ca       (ca)
    );

    // R10: an accepted request with work starts a frame on the next cycle
    a_r10_accept_then_frame: assert property (@(posedge clk) disable iff (rst)
        (accept && plan_cnt != '0) |=> (cs && !req_ready));

    // R9: precharge to an idle bank leaves the bus quiet
    a_r9_pre_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (accept && req_op == REQ_PRE && !look_open) |=> (!cs && req_ready));
endmodule

// File: tb/lp_cmd_encoder_tb_top.sv
module lp_cmd_encoder_tb_top;
    import lpce_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [1:0]       req_op = '0;
    logic [2:0]       req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic             req_bl32 = 1'b0;
    logic             cs;
    logic [CA_W-1:0]  ca;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [6:0] exp_q [$];
    string      tag_q [$];
    bit         m_open [8];
    int         m_row  [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    lp_cmd_encoder dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_bl32(req_bl32), .cs(cs), .ca(ca)
    );

    task automatic check(input logic [6:0] act, input logic [6:0] exp,
                         input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic push_cmd(input int op, input int bank, input int payload, input string tag);
        exp_q.push_back({1'b1, 3'(bank), 3'(op)});
        tag_q.push_back(tag);
        exp_q.push_back({1'b0, 6'(payload)});
        tag_q.push_back(tag);
    endtask

    // Reference model: frames pushed on acceptance, open-row state per bank
    task automatic model_accept(input int op, input int bank, input int row,
                                input int col, input bit bl, input string tag);
        bit acc = (op == 1) || (op == 2);
        bit hit = m_open[bank] && (m_row[bank] == row);
        if (m_open[bank] && (op == 0 || op == 3 || (acc && !hit)))
            push_cmd(6, bank, 0, tag);
        if (op == 0 || (acc && !hit)) begin
            push_cmd(1, bank, (row >> 6) & 63, tag);
            push_cmd(2, bank, row & 63, tag);
        end
        if (acc) begin
            push_cmd(op == 1 ? 3 : 4, bank, {bl, 1'b0, 4'((col >> 6) & 15)}, tag);
            push_cmd(5, 0, col & 63, tag);
        end
        if (op == 3) m_open[bank] = 0;
        else begin
            m_open[bank] = 1;
            m_row[bank]  = row;
        end
    endtask

    task automatic tick();
        logic [6:0] e;
        string t;
        @(negedge clk);
        if (exp_q.size() == 0) begin
            e = 7'h0;
            t = "R1";
        end else begin
            e = exp_q[0];
            t = tag_q[0];
        end
        check({cs, ca}, e, t, "cs/ca frame");
        check({6'h0, req_ready}, {6'h0, exp_q.size() == 0}, "R10", "req_ready");
        if (exp_q.size() != 0) begin
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
    endtask

    task automatic send(input int op, input int bank, input int row,
                        input int col, input bit bl, input string tag);
        int waits = 0;
        req_op    = 2'(op);
        req_bank  = 3'(bank);
        req_row   = ROW_W'(row);
        req_col   = COL_W'(col);
        req_bl32  = bl;
        req_valid = 1'b1;
        while (!req_ready && waits < 50) begin
            tick();
            waits++;
        end
        if (!req_ready) begin
            checks++;
            errors++;
            $display("FAIL R10 ready never returned: actual 0 expected 1");
        end else begin
            model_accept(op, bank, row, col, bl, tag);
        end
        tick();
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL R10 watchdog expired: actual hung expected finish");
        if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int b = 0; b < 8; b++) begin
            m_open[b] = 0;
            m_row[b]  = 0;
        end
        repeat (3) @(negedge clk);
        check({cs, ca}, 7'h0, "R1", "bus during reset");
        rst = 1'b0;
        idle(2);
        check({6'h0, req_ready}, 7'h1, "R1", "ready after reset");

        send(0, 0, 'hABC, 0, 0, "R3");          // activate idle bank
        idle(3);
        send(1, 0, 'hABC, 'h155, 1, "R7");      // row hit, burst 32
        idle(2);
        send(1, 1, 'h123, 'h3FF, 0, "R4");      // read to idle bank
        idle(1);
        send(2, 0, 'h456, 'h2A5, 1, "R8");      // row miss, write
        send(0, 0, 'h777, 0, 0, "R8");          // activate over open bank, back to back
        idle(2);
        send(3, 1, 0, 0, 0, "R9");              // precharge open bank
        idle(2);
        send(1, 1, 'h123, 'h040, 1, "R9");      // reopens after close
        idle(2);
        send(3, 5, 0, 0, 0, "R9");              // precharge idle bank: no frame
        idle(3);
        send(2, 7, 'hFFF, 'h3C0, 0, "R11");
        send(1, 0, 'h777, 'h011, 0, "R11");     // bank 0 unaffected by bank 7
        send(1, 3, 'h001, 'h2AA, 1, "R6");
        send(1, 3, 'h001, 'h155, 0, "R6");
        send(2, 3, 'h800, 'h07F, 1, "R5");
        send(2, 2, 'h5A5, 'h381, 0, "R2");
        idle(12);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule